// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block arbitrates sixteen numbered event levels for a processor core. Lower numbers mean higher priority. A software raise request or a hardware event pulse latches a level. Each cycle the controller finds the highest-priority latched level that is unmasked. It accepts that level only if it outranks every level already being serviced. When it accepts a level, it presents the level number and that level's 32-bit handler vector for one cycle. The level is then recorded as active until a return strobe retires it.

Software reaches the controller through a word-addressed register window. The window holds one handler vector per level, a 9-bit override register, the mask register, and read-only views of the active (pending) set and the latched set. Two dedicated operations handle interrupt disabling. The global-disable operation hands back the mask value and clears the mask. The enable operation reloads the mask. The five highest-priority levels can never be masked.

Top module: `evc_core`

## Requirements
- R1: The vector of level n (n = 1..15) lives at byte offset 4*n. A read returns the last value written there on `bus_rdata`, one cycle after the read is sampled.
- R2: The level-0 vector at offset 0x000 has no storage and always reads as 0. Level 0 is taken with vector 0.
- R3: The override register at offset 0x100 keeps only bits 8:0. Writing 0xFFFFFFFF reads back 0x000001FF.
- R4: The mask register at offset 0x104 reads as (written value & 0xFFFF) | 0x001F. Bits 31:16 read as 0.
- R5: Writes to the pending register (offset 0x108) and the latch register (offset 0x10C) have no effect. Any offset outside the mapped set reads as 0, and a write to it changes nothing.
- R6: A raise of level n sets bit n of the latch register. If mask bit n is 0, the bit stays set and the level is not taken. With mask 0x0FFF, raising levels 12 and 13 makes the latch read 0x3000.
- R7: A latched level whose mask bit is 1 is accepted only if its number is the lowest among such levels and is below the lowest set pending bit. On acceptance, the latch bit clears and the pending bit sets. `take_valid` is high for one cycle, with `take_lvl` and that level's vector on `take_vec`. This happens on the second rising edge after the raise is sampled.
- R8: `evt_return` clears the lowest set pending bit. A lower-priority latched level may then be accepted on the following edge.
- R9: `gdis_req` loads `gdis_mask` with the current mask and sets the mask to 0x001F. `en_req` loads `en_value | 0x001F` into the mask. When operations collide, `gdis_req` wins over `en_req`, and `en_req` wins over a bus write to the mask.
- R10: After reset, all vectors, the override register, the pending register and the latch register read 0, the mask reads 0x001F, and `take_valid` is 0.
- R11: A one-cycle high pulse on `hw_evt[n]` latches level n exactly as a software raise does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| sw_raise | input | 1 | Software raise request |
| sw_raise_lvl | input | 4 | Level to raise |
| hw_evt | input | 16 | Hardware event pulses, one per level |
| evt_return | input | 1 | Return-from-event strobe |
| gdis_req | input | 1 | Global-disable operation |
| gdis_mask | output | 16 | Mask value captured by the last global-disable |
| en_req | input | 1 | Enable operation |
| en_value | input | 16 | Mask value for the enable operation |
| take_valid | output | 1 | One-cycle acceptance strobe |
| take_lvl | output | 4 | Accepted level |
| take_vec | output | 32 | Handler vector of the accepted level |

## Verification
The register window is swept at every vector offset with a distinct computed pattern, so aliasing between levels and the missing level-0 storage both show up. The mask, override, read-only and unmapped offsets are tried with all-ones and sparse values. The arbitration core is swept over all sixteen levels one at a time, which checks the acceptance latency, the vector pairing and the pending bit position. It is then tried with nested raises in both priority orders, which separates "accept only if it outranks the active level" from plain priority selection. Masked raises, disable/enable sequences and hardware pulses show whether latching is kept apart from acceptance.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int N_LEVELS   = 16;
    localparam int N_LVL_W    = $clog2(N_LEVELS);
    localparam int N_VEC_W    = 32;
    localparam int N_FIXED    = 5;
    localparam int N_OVR_W    = 9;
    localparam int N_ADDR_W   = 12;

    localparam logic [N_ADDR_W-1:0] OFS_OVR  = 12'h100;
    localparam logic [N_ADDR_W-1:0] OFS_MASK = 12'h104;
    localparam logic [N_ADDR_W-1:0] OFS_PEND = 12'h108;
    localparam logic [N_ADDR_W-1:0] OFS_LAT  = 12'h10C;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_VEC,
        REG_OVR,
        REG_MASK,
        REG_PEND,
        REG_LAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e             sel;
        logic [N_LVL_W-1:0]   lvl;
    } reg_dec_t;

    function automatic reg_dec_t decode_ofs(logic [N_ADDR_W-1:0] a);
        reg_dec_t d;
        d.lvl = a[N_LVL_W+1:2];
        d.sel = REG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a < N_ADDR_W'(N_LEVELS * 4)) d.sel = REG_VEC;
            else if (a == OFS_OVR)           d.sel = REG_OVR;
            else if (a == OFS_MASK)          d.sel = REG_MASK;
            else if (a == OFS_PEND)          d.sel = REG_PEND;
            else if (a == OFS_LAT)           d.sel = REG_LAT;
        end
        return d;
    endfunction

endpackage

// File: rtl/evc_vectors.sv
module evc_vectors #(
    parameter int LEVELS = evc_pkg::N_LEVELS,
    parameter int LVL_W  = $clog2(LEVELS),
    parameter int VEC_W  = evc_pkg::N_VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [LVL_W-1:0] rd_lvl,
    output logic [VEC_W-1:0] rd_vec,
    input  logic [LVL_W-1:0] pick_lvl,
    output logic [VEC_W-1:0] pick_vec
);

    logic [VEC_W-1:0] vec_all [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slot
        if (g == 0) begin : g_hardwired
            assign vec_all[g] = '0;
        end else begin : g_stored
            logic [VEC_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q <= '0;
                else if (wr_en && wr_lvl == LVL_W'(g))
                    slot_q <= wr_data;
            end
            assign vec_all[g] = slot_q;
        end
    end

    assign rd_vec   = vec_all[rd_lvl];
    assign pick_vec = vec_all[pick_lvl];

endmodule

// File: rtl/evc_mask.sv
module evc_mask #(
    parameter int LEVELS = evc_pkg::N_LEVELS,
    parameter int FIXED  = evc_pkg::N_FIXED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [LEVELS-1:0] bus_val,
    input  logic              dis_req,
    input  logic              en_req,
    input  logic [LEVELS-1:0] en_val,
    output logic [LEVELS-1:0] mask_o,
    output logic [LEVELS-1:0] saved_o
);

    localparam logic [LEVELS-1:0] FORCED = {{(LEVELS-FIXED){1'b0}}, {FIXED{1'b1}}};

    logic [LEVELS-1:0] mask_q, saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= FORCED;
            saved_q <= '0;
        end else if (dis_req) begin
            saved_q <= mask_q;
            mask_q  <= FORCED;
        end else if (en_req) begin
            mask_q  <= en_val | FORCED;
        end else if (bus_wr) begin
            mask_q  <= bus_val | FORCED;
        end
    end

    assign mask_o  = mask_q;
    assign saved_o = saved_q;

    // R9
    gdis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dis_req |=> (mask_q == FORCED) && (saved_q == $past(mask_q)));

endmodule

// File: rtl/evc_sched.sv
module evc_sched #(
    parameter int LEVELS = evc_pkg::N_LEVELS,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] raise_bits,
    input  logic [LEVELS-1:0] mask,
    input  logic              ret,
    output logic [LEVELS-1:0] pend_o,
    output logic [LEVELS-1:0] lat_o,
    output logic              acc_o,
    output logic [LVL_W-1:0]  acc_lvl_o,
    output logic              take_valid,
    output logic [LVL_W-1:0]  take_lvl
);

    localparam logic [LEVELS-1:0] ONE = {{(LEVELS-1){1'b0}}, 1'b1};

    function automatic logic [LVL_W:0] first_one(logic [LEVELS-1:0] v);
        logic [LVL_W:0] r;
        r = (LVL_W+1)'(LEVELS);
        for (int i = LEVELS - 1; i >= 0; i--)
            if (v[i]) r = (LVL_W+1)'(i);
        return r;
    endfunction

    logic [LEVELS-1:0] lat_q, pend_q, lat_d, pend_d, acc_bit, ret_bit;
    logic [LVL_W:0]    cand_idx, act_idx;
    logic              acc;
    logic              take_q;
    logic [LVL_W-1:0]  take_lvl_q;

    always_comb begin
        cand_idx = first_one(lat_q & mask);
        act_idx  = first_one(pend_q);
        acc      = cand_idx < act_idx;
        acc_bit  = acc ? (ONE << cand_idx[LVL_W-1:0]) : '0;
        ret_bit  = (ret && pend_q != '0) ? (ONE << act_idx[LVL_W-1:0]) : '0;
        lat_d    = (lat_q & ~acc_bit) | raise_bits;
        pend_d   = (pend_q & ~ret_bit) | acc_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q      <= '0;
            pend_q     <= '0;
            take_q     <= 1'b0;
            take_lvl_q <= '0;
        end else begin
            lat_q      <= lat_d;
            pend_q     <= pend_d;
            take_q     <= acc;
            if (acc) take_lvl_q <= cand_idx[LVL_W-1:0];
        end
    end

    assign pend_o     = pend_q;
    assign lat_o      = lat_q;
    assign acc_o      = acc;
    assign acc_lvl_o  = cand_idx[LVL_W-1:0];
    assign take_valid = take_q;
    assign take_lvl   = take_lvl_q;

    // R7
    take_marks_pend_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> pend_q[take_lvl_q]);

    // R7
    one_new_pend_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pend_q & ~$past(pend_q)) <= 1);

    // R8
    ret_retires_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && pend_q != '0 && !acc) |=> $countones(pend_q) == $past($countones(pend_q)) - 1);

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0) && (lat_q == '0) && !take_q);

endmodule

// File: rtl/evc_core.sv
module evc_core
    import evc_pkg::*;
#(
    parameter int LEVELS = N_LEVELS,
    parameter int LVL_W  = $clog2(LEVELS),
    parameter int VEC_W  = N_VEC_W,
    parameter int ADDR_W = N_ADDR_W,
    parameter int OVR_W  = N_OVR_W,
    parameter int FIXED  = N_FIXED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [VEC_W-1:0]  bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata,
    input  logic              sw_raise,
    input  logic [LVL_W-1:0]  sw_raise_lvl,
    input  logic [LEVELS-1:0] hw_evt,
    input  logic              evt_return,
    input  logic              gdis_req,
    output logic [LEVELS-1:0] gdis_mask,
    input  logic              en_req,
    input  logic [LEVELS-1:0] en_value,
    output logic              take_valid,
    output logic [LVL_W-1:0]  take_lvl,
    output logic [VEC_W-1:0]  take_vec
);

    localparam logic [LEVELS-1:0] ONE = {{(LEVELS-1){1'b0}}, 1'b1};

    reg_dec_t          dec;
    logic              wr, rd;
    logic [VEC_W-1:0]  rd_vec, pick_vec, rd_val, rdata_q, take_vec_q;
    logic [OVR_W-1:0]  ovr_q;
    logic [LEVELS-1:0] mask, pend, lat, raise_bits;
    logic              acc;
    logic [LVL_W-1:0]  acc_lvl;

    assign dec = decode_ofs(bus_addr);
    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;

    assign raise_bits = hw_evt | (sw_raise ? (ONE << sw_raise_lvl) : '0);

    evc_vectors #(.LEVELS(LEVELS), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_vec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr && dec.sel == REG_VEC),
        .wr_lvl   (dec.lvl),
        .wr_data  (bus_wdata),
        .rd_lvl   (dec.lvl),
        .rd_vec   (rd_vec),
        .pick_lvl (acc_lvl),
        .pick_vec (pick_vec)
    );

    evc_mask #(.LEVELS(LEVELS), .FIXED(FIXED)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .bus_wr  (wr && dec.sel == REG_MASK),
        .bus_val (bus_wdata[LEVELS-1:0]),
        .dis_req (gdis_req),
        .en_req  (en_req),
        .en_val  (en_value),
        .mask_o  (mask),
        .saved_o (gdis_mask)
    );

    evc_sched #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .raise_bits (raise_bits),
        .mask       (mask),
        .ret        (evt_return),
        .pend_o     (pend),
        .lat_o      (lat),
        .acc_o      (acc),
        .acc_lvl_o  (acc_lvl),
        .take_valid (take_valid),
        .take_lvl   (take_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= '0;
        else if (wr && dec.sel == REG_OVR)
            ovr_q <= bus_wdata[OVR_W-1:0];
    end

    always_comb begin
        case (dec.sel)
            REG_VEC:  rd_val = rd_vec;
            REG_OVR:  rd_val = VEC_W'(ovr_q);
            REG_MASK: rd_val = VEC_W'(mask);
            REG_PEND: rd_val = VEC_W'(pend);
            REG_LAT:  rd_val = VEC_W'(lat);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            take_vec_q <= '0;
        end else begin
            if (rd)  rdata_q    <= rd_val;
            if (acc) take_vec_q <= pick_vec;
        end
    end

    assign bus_rdata = rdata_q;
    assign take_vec  = take_vec_q;

    // R2
    lvl0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr == '0) |=> bus_rdata == '0);

    // R2
    lvl0_take_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_lvl == '0) |-> take_vec == '0);

endmodule

// File: tb/tb_evc_core.sv
module tb_evc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sw_raise = 0;
    logic [3:0]  sw_raise_lvl = '0;
    logic [15:0] hw_evt = '0;
    logic        evt_return = 0;
    logic        gdis_req = 0;
    logic [15:0] gdis_mask;
    logic        en_req = 0;
    logic [15:0] en_value = '0;
    logic        take_valid;
    logic [3:0]  take_lvl;
    logic [31:0] take_vec;

    int checks = 0, fails = 0, takes = 0;
    logic [3:0]  last_lvl;
    logic [31:0] last_vec;
    logic [31:0] rv;
    bit done = 0;

    evc_core dut (.*);

    always #4 clk = ~clk;

    always @(negedge clk) if (take_valid) begin
        takes++;
        last_lvl = take_lvl;
        last_vec = take_vec;
    end

    function automatic logic [31:0] pat(int n);
        logic [31:0] p;
        p = 32'h9E3779B9 * 32'(n + 1);
        return (n == 0) ? 32'h0 : p;
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        step();
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
        logic [31:0] d;
        rd(a, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic raise(int n);
        sw_raise = 1; sw_raise_lvl = 4'(n);
        step();
        sw_raise = 0;
    endtask

    task automatic retire();
        evt_return = 1;
        step();
        evt_return = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) step();
        rst = 0;
        step();

        // R10 reset state
        chk(take_valid == 0, "R10 take_valid", 32'(take_valid), 0);
        rd_chk(12'h104, 32'h1F, "R10 mask");
        rd_chk(12'h108, 32'h0, "R10 pending");
        rd_chk(12'h10C, 32'h0, "R10 latch");
        rd_chk(12'h100, 32'h0, "R10 override");
        rd_chk(12'h00C, 32'h0, "R10 vector3");

        // R1 / R2 vector sweep
        for (int n = 0; n < 16; n++) wr(12'(4 * n), 32'h9E3779B9 * 32'(n + 1));
        for (int n = 0; n < 16; n++)
            rd_chk(12'(4 * n), pat(n), n == 0 ? "R2 level0 vector" : "R1 vector readback");

        // R3 override
        wr(12'h100, 32'hFFFFFFFF);
        rd_chk(12'h100, 32'h1FF, "R3 override all ones");
        wr(12'h100, 32'h0000_00AA);
        rd_chk(12'h100, 32'hAA, "R3 override sparse");

        // R4 mask sweep
        begin
            logic [31:0] mv [5] = '{32'h0, 32'h0FFF, 32'hFFFFFFFF, 32'h0001_2340, 32'h0000_8001};
            for (int i = 0; i < 5; i++) begin
                wr(12'h104, mv[i]);
                rd_chk(12'h104, (mv[i] & 32'hFFFF) | 32'h1F, "R4 mask readback");
            end
        end

        // R5 read-only and unmapped
        wr(12'h108, 32'hFFFFFFFF);
        rd_chk(12'h108, 32'h0, "R5 pending write ignored");
        wr(12'h10C, 32'hFFFFFFFF);
        rd_chk(12'h10C, 32'h0, "R5 latch write ignored");
        wr(12'h0FC, 32'hDEADBEEF);
        rd_chk(12'h0FC, 32'h0, "R5 unmapped reads zero");
        wr(12'h016, 32'hDEADBEEF);
        rd_chk(12'h014, pat(5), "R5 misaligned write ignored");
        rd_chk(12'h110, 32'h0, "R5 unmapped high");
        chk(takes == 0, "R5 no spurious take", 32'(takes), 0);

        // R6 masked raises stay latched
        wr(12'h104, 32'h0FFF);
        raise(12); raise(13);
        step(); step();
        rd_chk(12'h10C, 32'h3000, "R6 latch 12 13");
        rd_chk(12'h108, 32'h0, "R6 pending unchanged");
        chk(takes == 0, "R6 not taken", 32'(takes), 0);

        // R9 enable releases; R7 priority; R8 return
        en_value = 16'hFFFF; en_req = 1; step(); en_req = 0;
        step(); step();
        chk(takes == 1 && last_lvl == 12, "R7 level12 first", 32'(last_lvl), 12);
        chk(last_vec == pat(12), "R7 vector 12", last_vec, pat(12));
        rd_chk(12'h108, 32'h1000, "R7 pending 12");
        rd_chk(12'h10C, 32'h2000, "R7 latch 13 waits");
        retire(); step(); step();
        chk(takes == 2 && last_lvl == 13, "R8 level13 after return", 32'(last_lvl), 13);
        rd_chk(12'h108, 32'h2000, "R8 pending 13");
        retire(); step();
        rd_chk(12'h108, 32'h0, "R8 pending empty");

        // R7 per-level sweep with exact timing
        for (int n = 0; n < 16; n++) begin
            t0 = takes;
            raise(n);
            chk(take_valid == 0, "R7 not yet after one edge", 32'(take_valid), 0);
            step();
            chk(take_valid == 1 && take_lvl == 4'(n), "R7 take timing/level", 32'(take_lvl), 32'(n));
            chk(take_vec == pat(n), "R7 take vector", take_vec, pat(n));
            step();
            chk(takes == t0 + 1, "R7 single cycle strobe", 32'(takes - t0), 1);
            rd_chk(12'h108, 32'h1 << n, "R7 pending bit");
            retire(); step();
            rd_chk(12'h108, 32'h0, "R8 retired");
        end

        // R7 nesting: higher priority preempts, lower waits
        raise(15); step(); step();
        rd_chk(12'h108, 32'h8000, "R7 pending 15 alone");
        raise(14); step(); step();
        rd_chk(12'h108, 32'hC000, "R7 nested 14 over 15");
        t0 = takes;
        raise(15); step(); step();
        chk(takes == t0, "R7 equal level not accepted", 32'(takes - t0), 0);
        retire(); step();
        rd_chk(12'h108, 32'h8000, "R8 clears lowest bit");
        retire(); step(); step();
        chk(takes == t0 + 1 && last_lvl == 15, "R8 queued 15 accepted", 32'(last_lvl), 15);
        retire(); step();
        rd_chk(12'h108, 32'h0, "R8 all retired");

        // R9 disable / enable
        wr(12'h104, 32'h0F0F);
        gdis_req = 1; step(); gdis_req = 0;
        chk(gdis_mask == 16'h0F1F, "R9 saved mask", 32'(gdis_mask), 32'h0F1F);
        rd_chk(12'h104, 32'h1F, "R9 mask cleared");
        t0 = takes;
        raise(8); step(); step();
        chk(takes == t0, "R9 masked while disabled", 32'(takes - t0), 0);
        en_value = 16'h0100; en_req = 1; step(); en_req = 0;
        rd_chk(12'h104, 32'h011F, "R9 enable value");
        step();
        chk(takes == t0 + 1 && last_lvl == 8, "R9 taken after enable", 32'(last_lvl), 8);
        retire(); step();
        gdis_req = 1; en_req = 1; en_value = 16'hFFFF; step(); gdis_req = 0; en_req = 0;
        rd_chk(12'h104, 32'h1F, "R9 disable wins over enable");
        en_req = 1; en_value = 16'h0200;
        bus_sel = 1; bus_we = 1; bus_addr = 12'h104; bus_wdata = 32'hFFFF;
        step();
        en_req = 0; bus_sel = 0; bus_we = 0;
        rd_chk(12'h104, 32'h021F, "R9 enable wins over bus write");

        // R11 hardware pulse
        wr(12'h104, 32'hFFFF);
        t0 = takes;
        hw_evt = 16'h0200; step(); hw_evt = '0;
        step();
        chk(take_valid == 1 && take_lvl == 9, "R11 hw event taken", 32'(take_lvl), 9);
        chk(take_vec == pat(9), "R11 hw vector", take_vec, pat(9));
        retire(); step();
        rd_chk(12'h108, 32'h0, "R11 retired");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule